// File: doc/BRIEF.md
# Serial Configuration Register Target

This block lets an external two-wire bus master program a bank of 8-bit configuration registers inside the chip. It samples the clock and data lines through synchronizer flops, detects START and STOP conditions, answers to one fixed 7-bit device address, and drives the data line only by pulling it low. The surrounding logic can read any register over a parallel side port. One register bit acts as a one-way "go" control.

Access follows the usual small serial EEPROM pattern. After the write address byte, the first data byte sets a register pointer, and any later bytes in the same transfer are stored at that pointer. A read transfer, started directly or after a repeated START, returns bytes from the current pointer. The pointer advances after every byte moved. The block responds only while a two-bit mode input selects it.

Top module: `i2c_cfg_target`

## Requirements
- R1: The block takes part in bus traffic only while `modeSel` equals 2'b01. With any other value it never pulls SDA low and no register or pointer changes. If the mode is withdrawn during a transfer, the block releases SDA on the next cycle.
- R2: After a START, the block acknowledges the address byte 8'hBE (write) and 8'hBF (read). Any other address byte gets no acknowledge, and every byte that follows is ignored until the next START.
- R3: The bank holds 128 registers of 8 bits each, all cleared by reset. Register n is visible on `cfgData` when `cfgAddr` = n. SDA is released after reset.
- R4: In a write transfer, the first byte after the address loads the 8-bit register pointer. Each later byte is stored at the pointer and acknowledged.
- R5: The pointer advances by one after every data byte written or read. It wraps from 127 to 0 and from 255 to 0.
- R6: A read transfer sends bytes MSB first, starting at the current pointer. The block continues while the master acknowledges. After the master's NACK it releases SDA and stays released.
- R7: Register 1 bit 0 drives `startOut` and resets to 0. Once written to 1, later writes of 0 leave it at 1 until reset. The other seven bits of register 1 behave like normal storage.
- R8: Data bytes written while the pointer is in the range 128 to 255 are acknowledged but not stored. Reads in that range return 8'h00.
- R9: A STOP ends any transfer and keeps the pointer. A repeated START begins a new address phase, which allows a pointer write followed by a read.
- R10: The block changes its SDA drive only while SCL is low, never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Interface select; 2'b01 enables the target |
| sclIn | input | 1 | Serial clock line as seen on the pad |
| sdaIn | input | 1 | Serial data line as seen on the pad |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfgAddr | input | 7 | Register index for the side read port |
| cfgData | output | 8 | Contents of the register at `cfgAddr` |
| startOut | output | 1 | Sticky start control (register 1 bit 0) |

## Verification
A corrupted pointer shows up in the first read byte after it. It also shows on the side port one cycle after the next stored write, as data landing in the wrong register. A wrong bit counter or phase state makes SDA disagree with the master on the very next acknowledge slot, or shifts read data by one bit within one byte. A lost sticky bit is seen on `startOut` on the cycle after the write of 0 that cleared it.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int BYTE_W = 8;

  // Strobes from the bus controller to the register datapath, one cycle each.
  typedef struct packed {
    logic              loadPtr;
    logic              writeByte;
    logic              incPtr;
    logic [BYTE_W-1:0] data;
  } regStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } linkState_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] syncOut,
  output logic [LINES-1:0] prevOut
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '1;
        prevQ <= 1'b1;
      end else begin
        if (STAGES > 1) begin
          chain <= {chain[STAGES-2:0], rawIn[g]};
        end else begin
          chain <= rawIn[g];
        end
        prevQ <= chain[STAGES-1];
      end
    end

    assign syncOut[g] = chain[STAGES-1];
    assign prevOut[g] = prevQ;
  end

endmodule

// File: rtl/i2c_link_ctrl.sv
module i2c_link_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5F,
  parameter logic [1:0] MODE_ON  = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              sclP,
  input  logic              sdaP,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sdaOe,
  output regStrobe_t        strobe
);

  localparam logic [3:0] BIT_LAST = 4'd7;
  localparam logic [3:0] BIT_FULL = 4'd8;

  linkState_t        state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic              isRead;
  logic              needPtr;
  logic              masterAck;

  logic modeOk, sclRise, sclFall, startSeen, stopSeen;

  assign modeOk    = (modeSel == MODE_ON);
  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      isRead    <= 1'b0;
      needPtr   <= 1'b0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
      strobe    <= '0;
    end else begin
      strobe <= '0;
      if (!modeOk) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else if (startSeen) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopSeen) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;

          ST_ADDR: begin
            if (sclRise) begin
              rxShift <= {rxShift[BYTE_W-2:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == BIT_FULL) begin
              if (rxShift[BYTE_W-1:1] == DEV_ADDR) begin
                isRead <= rxShift[0];
                sdaOe  <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end

          ST_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                txShift <= rdData;
                sdaOe   <= ~rdData[BYTE_W-1];
                state   <= ST_RD_BYTE;
              end else begin
                sdaOe   <= 1'b0;
                needPtr <= 1'b1;
                state   <= ST_WR_BYTE;
              end
            end
          end

          ST_WR_BYTE: begin
            if (sclRise) begin
              rxShift <= {rxShift[BYTE_W-2:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == BIT_FULL) begin
              strobe.loadPtr   <= needPtr;
              strobe.writeByte <= ~needPtr;
              strobe.data      <= rxShift;
              needPtr          <= 1'b0;
              sdaOe            <= 1'b1;
              state            <= ST_WR_ACK;
            end
          end

          ST_WR_ACK: begin
            if (sclFall) begin
              sdaOe  <= 1'b0;
              bitCnt <= '0;
              state  <= ST_WR_BYTE;
            end
          end

          ST_RD_BYTE: begin
            if (sclFall) begin
              if (bitCnt == BIT_LAST) begin
                sdaOe         <= 1'b0;
                strobe.incPtr <= 1'b1;
                state         <= ST_RD_ACK;
              end else begin
                bitCnt  <= bitCnt + 4'd1;
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                sdaOe   <= ~txShift[BYTE_W-2];
              end
            end
          end

          ST_RD_ACK: begin
            if (sclRise) begin
              masterAck <= ~sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                txShift <= rdData;
                sdaOe   <= ~rdData[BYTE_W-1];
                bitCnt  <= '0;
                state   <= ST_RD_BYTE;
              end else begin
                state <= ST_IDLE;
              end
            end
          end

          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !modeOk |=> !sdaOe); // R1

  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ADDR_ACK |-> rxShift[BYTE_W-1:1] == DEV_ADDR); // R2

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RD_ACK |-> !sdaOe); // R6

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    sclS && sclP && modeOk |-> $stable(sdaOe)); // R10

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_reg_pkg::*;
#(
  parameter int REG_COUNT = 128,
  parameter int START_REG = 1,
  parameter int START_BIT = 0,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] cfgData,
  output logic              startOut
);

  localparam logic [BYTE_W-1:0] LAST_IDX    = BYTE_W'(REG_COUNT - 1);
  localparam logic [BYTE_W:0]   COUNT_EXT   = (BYTE_W + 1)'(REG_COUNT);
  localparam logic [BYTE_W-1:0] STICKY_MASK = BYTE_W'(1) << START_BIT;

  logic [REG_COUNT-1:0][BYTE_W-1:0] regs;
  logic [REG_COUNT-1:0][BYTE_W-1:0] regNext;
  logic [BYTE_W-1:0]                ptr;
  logic [BYTE_W-1:0]                ptrNext;
  logic                             inRange;

  assign inRange = {1'b0, ptr} < COUNT_EXT;
  assign ptrNext = (ptr == LAST_IDX) ? '0 : ptr + 1'b1;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] IDX = BYTE_W'(i);
    logic hit;
    assign hit = strobe.writeByte && (ptr == IDX);
    if (i == START_REG) begin : g_sticky
      assign regNext[i] = hit ? (strobe.data | (regs[i] & STICKY_MASK)) : regs[i];
    end else begin : g_plain
      assign regNext[i] = hit ? strobe.data : regs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
      ptr  <= '0;
    end else begin
      regs <= regNext;
      if (strobe.loadPtr) begin
        ptr <= strobe.data;
      end else if (strobe.writeByte || strobe.incPtr) begin
        ptr <= ptrNext;
      end
    end
  end

  assign rdData   = inRange ? regs[ptr[ADDR_W-1:0]] : '0;
  assign cfgData  = regs[cfgAddr];
  assign startOut = regs[START_REG][START_BIT];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.loadPtr, strobe.writeByte, strobe.incPtr}) <= 1); // R4

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeByte || strobe.incPtr) && ptr == LAST_IDX |=> ptr == '0); // R5

  AST_START_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    startOut |=> startOut); // R7

  AST_START_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeByte && ptr == BYTE_W'(START_REG) && strobe.data[START_BIT] |=> startOut); // R7

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_reg_pkg::*;
#(
  parameter int         REG_COUNT   = 128,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h5F,
  parameter logic [1:0] MODE_ON     = 2'b01,
  localparam int        ADDR_W      = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic [BYTE_W-1:0] cfgData,
  output logic              startOut
);

  logic [1:0]        lineSync;
  logic [1:0]        linePrev;
  logic [BYTE_W-1:0] rdData;
  regStrobe_t        strobe;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES),
    .LINES (2)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({sclIn, sdaIn}),
    .syncOut(lineSync),
    .prevOut(linePrev)
  );

  i2c_link_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .MODE_ON (MODE_ON)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .sclS   (lineSync[1]),
    .sdaS   (lineSync[0]),
    .sclP   (linePrev[1]),
    .sdaP   (linePrev[0]),
    .rdData (rdData),
    .sdaOe  (sdaOe),
    .strobe (strobe)
  );

  i2c_reg_bank #(
    .REG_COUNT(REG_COUNT),
    .START_REG(1),
    .START_BIT(0)
  ) u_bank (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgAddr (cfgAddr),
    .rdData  (rdData),
    .cfgData (cfgData),
    .startOut(startOut)
  );

endmodule

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b01;
  logic       mScl = 1'b1;
  logic       mSdaLow = 1'b0;
  logic       sdaOe;
  logic       sdaBus;
  logic [6:0] cfgAddr = '0;
  logic [7:0] cfgData;
  logic       startOut;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  int  holdViol = 0;

  logic [7:0] mdlRegs [128];
  int         mdlPtr = 0;

  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] actQ [$];

  always #2 clk = ~clk;

  assign sdaBus = !(mSdaLow || sdaOe);

  i2c_cfg_target uut (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .sclIn   (mScl),
    .sdaIn   (sdaBus),
    .sdaOe   (sdaOe),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .startOut(startOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: compares each byte read over the bus with the model.
  initial begin
    forever begin
      @(negedge clk);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] a;
        logic [7:0] e;
        string      t;
        a = actQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, "read byte", int'(a), int'(e));
      end
    end
  end

  // R10: SDA drive must not move during an SCL high phase.
  logic prevScl = 1'b1;
  logic prevOe  = 1'b0;
  always @(negedge clk) begin
    if (rstN && mScl && prevScl && (sdaOe != prevOe)) holdViol++;
    prevScl <= mScl;
    prevOe  <= sdaOe;
  end

  function automatic void mdlAdvance();
    mdlPtr = (mdlPtr == 127) ? 0 : (mdlPtr + 1) % 256;
  endfunction

  function automatic void mdlWrite(input logic [7:0] b);
    if (mdlPtr < 128) begin
      if (mdlPtr == 1) mdlRegs[1] = b | (mdlRegs[1] & 8'h01);
      else mdlRegs[mdlPtr] = b;
    end
    mdlAdvance();
  endfunction

  function automatic logic [7:0] mdlRead();
    logic [7:0] v;
    v = (mdlPtr < 128) ? mdlRegs[mdlPtr] : 8'h00;
    mdlAdvance();
    return v;
  endfunction

  task automatic busStart();
    mSdaLow = 1'b0; qwait(Q);
    mScl = 1'b1;    qwait(Q);
    mSdaLow = 1'b1; qwait(Q);
    mScl = 1'b0;    qwait(2);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; qwait(Q);
    mScl = 1'b1;    qwait(Q);
    mSdaLow = 1'b0; qwait(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = !b[i]; qwait(Q);
      mScl = 1'b1;     qwait(Q);
      mScl = 1'b0;     qwait(2);
    end
    mSdaLow = 1'b0; qwait(Q);
    mScl = 1'b1;    qwait(Q / 2);
    acked = !sdaBus;
    qwait(Q / 2);
    mScl = 1'b0;    qwait(2);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qwait(Q);
      mScl = 1'b1; qwait(Q / 2);
      b[i] = sdaBus;
      qwait(Q / 2);
      mScl = 1'b0;
    end
    qwait(2);
    mSdaLow = ackIt; qwait(Q);
    mScl = 1'b1;     qwait(Q);
    mScl = 1'b0;     qwait(2);
    mSdaLow = 1'b0;
  endtask

  // Driver for a write transfer; every byte's acknowledge is checked.
  task automatic doWrite(input string req, input logic [7:0] dev, input logic [7:0] ptrByte,
                         input logic [7:0] data [$], input bit expAck);
    bit a;
    busStart();
    sendByte(dev, a);
    chk(req, "address ack", int'(a), int'(expAck));
    sendByte(ptrByte, a);
    chk(req, "pointer ack", int'(a), int'(expAck));
    if (expAck) mdlPtr = ptrByte;
    foreach (data[k]) begin
      sendByte(data[k], a);
      chk(req, "data ack", int'(a), int'(expAck));
      if (expAck) mdlWrite(data[k]);
    end
    busStop();
  endtask

  task automatic readBurst(input string req, input int n);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      expQ.push_back(mdlRead());
      tagQ.push_back(req);
      recvByte(k != n - 1, b);
      actQ.push_back(b);
    end
    busStop();
    qwait(4);
    chk(req, "sda released after nack", int'(sdaOe), 0);
  endtask

  task automatic ptrRead(input string req, input logic [7:0] p, input int n);
    bit a;
    busStart();
    sendByte(8'hBE, a);
    chk(req, "write address ack", int'(a), 1);
    sendByte(p, a);
    chk(req, "pointer ack", int'(a), 1);
    mdlPtr = p;
    busStart();
    sendByte(8'hBF, a);
    chk(req, "read address ack", int'(a), 1);
    readBurst(req, n);
  endtask

  task automatic curRead(input string req, input int n);
    bit a;
    busStart();
    sendByte(8'hBF, a);
    chk(req, "read address ack", int'(a), 1);
    readBurst(req, n);
  endtask

  task automatic cfgPeek(input string req, input int idx);
    cfgAddr = 7'(idx);
    qwait(1);
    chk(req, $sformatf("register %0d", idx), int'(cfgData), int'(mdlRegs[idx]));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d [$];
    bit a;
    foreach (mdlRegs[i]) mdlRegs[i] = 8'h00;
    qwait(5);
    rstN = 1'b1;
    qwait(5);

    // R3 reset state
    chk("R3", "sdaOe after reset", int'(sdaOe), 0);
    chk("R7", "startOut after reset", int'(startOut), 0);
    cfgPeek("R3", 1);
    cfgPeek("R3", 127);

    // R4 pointer then data bytes
    d = '{8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h69};
    doWrite("R4", 8'hBE, 8'h10, d, 1'b1);
    for (int i = 16; i < 21; i++) cfgPeek("R4", i);

    // R6 pointer-then-read with repeated start, then continue at current pointer (R9)
    ptrRead("R6", 8'h10, 3);
    curRead("R6", 2);

    // R5 wrap from 127 to 0
    d = '{8'h11, 8'h22, 8'h33};
    doWrite("R5", 8'hBE, 8'd126, d, 1'b1);
    cfgPeek("R5", 126);
    cfgPeek("R5", 127);
    cfgPeek("R5", 0);
    ptrRead("R5", 8'd126, 3);

    // R8 high pointer writes acked but discarded; 255 wraps to 0 (R5)
    d = '{8'h77};
    doWrite("R8", 8'hBE, 8'd200, d, 1'b1);
    cfgPeek("R8", 72);
    d = '{8'h88, 8'h99};
    doWrite("R8", 8'hBE, 8'd255, d, 1'b1);
    cfgPeek("R8", 127);
    cfgPeek("R5", 0);
    ptrRead("R8", 8'd130, 1);

    // R7 sticky start bit
    d = '{8'hF0};
    doWrite("R7", 8'hBE, 8'd1, d, 1'b1);
    chk("R7", "startOut before set", int'(startOut), 0);
    cfgPeek("R7", 1);
    d = '{8'h01};
    doWrite("R7", 8'hBE, 8'd1, d, 1'b1);
    chk("R7", "startOut after set", int'(startOut), 1);
    d = '{8'h00};
    doWrite("R7", 8'hBE, 8'd1, d, 1'b1);
    chk("R7", "startOut after write of 0", int'(startOut), 1);
    cfgPeek("R7", 1);
    d = '{8'hF0};
    doWrite("R7", 8'hBE, 8'd1, d, 1'b1);
    cfgPeek("R7", 1);

    // R2 foreign addresses ignored, then own address still works
    d = '{8'hEE};
    doWrite("R2", 8'hA0, 8'h40, d, 1'b0);
    doWrite("R2", 8'hBC, 8'h40, d, 1'b0);
    cfgPeek("R2", 64);
    curRead("R2", 1);

    // R1 mode select gates everything
    modeSel = 2'b00;
    qwait(4);
    d = '{8'h55};
    doWrite("R1", 8'hBE, 8'h20, d, 1'b0);
    modeSel = 2'b11;
    qwait(4);
    doWrite("R1", 8'hBE, 8'h20, d, 1'b0);
    modeSel = 2'b01;
    qwait(4);
    cfgPeek("R1", 32);
    curRead("R1", 1);
    // mode withdrawn while the target holds an acknowledge
    busStart();
    sendByte(8'hBE, a);
    chk("R1", "address ack before withdraw", int'(a), 1);
    sendByte(8'h20, a);
    mdlPtr = 8'h20;
    modeSel = 2'b10;
    qwait(4);
    chk("R1", "sda released on withdraw", int'(sdaOe), 0);
    busStop();
    modeSel = 2'b01;
    qwait(4);

    // R9 pointer set, STOP, later read resumes at that pointer
    busStart();
    sendByte(8'hBE, a);
    chk("R9", "address ack", int'(a), 1);
    sendByte(8'h12, a);
    chk("R9", "pointer ack", int'(a), 1);
    mdlPtr = 8'h12;
    busStop();
    curRead("R9", 2);

    qwait(10);
    chk("R10", "sda changes during scl high", holdViol, 0);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule